// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the tag and state directory of a set-associative cache. It holds no line data. For every way it keeps a valid bit, the upper address bits of the line, a two-bit access-permission code and a reservation lock owned by a context. Each cycle a controller may issue one command against a line address. The block can look the line up, allocate or free it, change its permission, and set, clear or test its lock. It can also report whether the set still has room and, when it does not, name the line that should be evicted.

The lookup that most commands use treats a way whose permission is "not present" as absent. A separate lookup accepts any valid way. An access command is a hit only when the permission allows the request type. A per-set replacement unit tracks how recently each way was used. A parameter selects true LRU (age counters) or a binary-tree pseudo-LRU. Every command is answered through one registered response, one cycle later.

Top module: `ctd_dir`

## Requirements
- R1: With block size B bytes, cache size C bytes and W ways, the number of sets is C/W/B and must be at least 2. The set index is the log2(sets) address bits just above the log2(B) offset bits. The tag is the rest of the address above the set index. Offset bits are ignored.
- R2: Command codes (cmd_i): 0 idle, 1 access, 2 present test, 3 find ignoring permission, 4 availability, 5 allocate, 6 deallocate, 7 victim probe, 8 set permission, 9 read permission, 10 lock set, 11 lock clear, 12 lock test. The response appears on the clock edge after the command. rsp_valid_o is 1 exactly when that command was not idle. Fields that do not apply read 0.
- R3: Permission codes are 0 not present, 1 invalid, 2 read-only and 3 read-write. Request codes (req_i) are 0 load, 1 instruction fetch and 2 store. An access sets rsp_flag_o on a read-write line for any request. On a read-only line it sets the flag only for a load or a fetch. In every other case the access misses.
- R4: The normal lookup matches only a valid way with an equal tag whose permission is not 0. The way reported is the lowest matching way. Present test (2) returns that match. Find (3) also matches ways with permission 0.
- R5: An access whose normal lookup finds the line marks that way most recently used, even when the permission check turns the access into a miss.
- R6: The availability check is 1 when a valid way of the set holds the same tag, or when some way of the set is empty or has permission 0.
- R7: Allocate succeeds only when the normal lookup misses and a free way exists. It fills the lowest empty or permission-0 way with the tag, sets permission 1, clears the lock and marks the way most recently used. The flag and the way are reported. Otherwise it reports flag 0 and changes nothing.
- R8: Deallocate empties the way found by the normal lookup and clears its lock. The flag reports whether a line was found.
- R9: The victim probe returns, in rsp_addr_o, the line address (offset zero) of the way chosen by the replacement policy, and that way in rsp_way_o. rsp_flag_o is 1 when the availability check is 0.
- R10: In LRU mode the victim is the way of the set touched least recently. After reset, recency runs from way 0 (newest) to the highest way (oldest).
- R11: In pseudo-LRU mode each set keeps a tree of W-1 bits, all 0 after reset. A touch points every node on the way's path toward the other half. The victim is found by following the nodes from the root, where 0 means the lower half.
- R12: Lock set stores ctx_i as owner of the found line. Lock clear unlocks it. Lock test returns 1 only if the line is found, locked and owned by ctx_i.
- R13: Set permission writes perm_i to the found line and clears its lock unless perm_i is 3. Read permission returns the stored code in rsp_perm_o.
- R14: After reset every way is empty and unlocked, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Command code |
| addr_i | input | ADDR_W | Line address of the command |
| req_i | input | 2 | Request type for access |
| perm_i | input | 2 | New permission for set permission |
| ctx_i | input | CTX_W | Context for lock set and lock test |
| rsp_valid_o | output | 1 | Response present |
| rsp_flag_o | output | 1 | Boolean result of the command |
| rsp_way_o | output | log2(WAYS) | Way found, filled or chosen as victim |
| rsp_addr_o | output | ADDR_W | Victim line address on a probe |
| rsp_perm_o | output | 2 | Permission read back |

## Verification
The hardest situations to reach are a full set whose victim depends on a long history of touches, and a stale tag parked under permission 0 beside an empty lower way. The stimulus confines addresses to two sets and six tags, so sets fill, overflow and mix permission-0 leftovers with live lines. Two instances, one per replacement variant, receive the same commands. A behavioural model, using a recency queue per set and a recursive tree walk, predicts every response. A directed prologue first walks one line through every permission, lock and eviction step.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_ACCESS  = 4'd1,
        CMD_PRESENT = 4'd2,
        CMD_FIND    = 4'd3,
        CMD_AVAIL   = 4'd4,
        CMD_ALLOC   = 4'd5,
        CMD_DEALLOC = 4'd6,
        CMD_PROBE   = 4'd7,
        CMD_SETPERM = 4'd8,
        CMD_GETPERM = 4'd9,
        CMD_LKSET   = 4'd10,
        CMD_LKCLR   = 4'd11,
        CMD_LKTEST  = 4'd12
    } cmd_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_INV  = 2'd1,
        PERM_RO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_FETCH = 2'd1,
        REQ_STORE = 2'd2
    } req_e;
endpackage

// File: rtl/ctd_match.sv
// Per-way comparison of one set against a tag, with lowest-index encoders.
module ctd_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            vld_i,
    input  logic [WAYS-1:0]            gone_i,   // permission code is 0
    input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]           tag_q_i,
    output logic [WAYS-1:0]            hit_vec_o,
    output logic [WAYS-1:0]            any_vec_o,
    output logic [WAYS-1:0]            free_vec_o,
    output logic [WAY_W-1:0]           hit_idx_o,
    output logic [WAY_W-1:0]           any_idx_o,
    output logic [WAY_W-1:0]           free_idx_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign any_vec_o[w]  = vld_i[w] && (tag_i[w] == tag_q_i);
        assign hit_vec_o[w]  = any_vec_o[w] && !gone_i[w];
        assign free_vec_o[w] = !vld_i[w] || gone_i[w];
    end

    always_comb begin
        hit_idx_o  = '0;
        any_idx_o  = '0;
        free_idx_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec_o[w])  hit_idx_o  = WAY_W'(w);
            if (any_vec_o[w])  any_idx_o  = WAY_W'(w);
            if (free_vec_o[w]) free_idx_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ctd_repl.sv
// Per-set recency tracking: age counters (LRU) or a node tree (pseudo-LRU).
module ctd_repl #(
    parameter int SETS     = 4,
    parameter int WAYS     = 4,
    parameter bit USE_PLRU = 1'b0,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic [SET_W-1:0] set_i,
    input  logic [WAY_W-1:0] way_i,
    output logic [WAY_W-1:0] victim_o
);
    if (USE_PLRU) begin : g_plru
        logic [SETS-1:0][WAYS-2:0] tr_d, tr_q;

        always_comb begin
            int node;
            tr_d = tr_q;
            if (touch_i) begin
                for (int d = 0; d < WAY_W; d++) begin
                    node = (1 << d) | (int'(way_i) >> (WAY_W - d));
                    tr_d[set_i][node-1] = ~way_i[WAY_W-1-d];
                end
            end
            node = 1;
            for (int d = 0; d < WAY_W; d++) begin
                node = 2 * node + int'(tr_q[set_i][node-1]);
            end
            victim_o = WAY_W'(node - WAYS);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) tr_q <= '0;
            else        tr_q <= tr_d;
        end
    end else begin : g_lru
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;

        always_comb begin
            logic [WAY_W-1:0] old;
            age_d = age_q;
            old   = age_q[set_i][way_i];
            if (touch_i) begin
                for (int v = 0; v < WAYS; v++) begin
                    if (WAY_W'(v) == way_i)       age_d[set_i][v] = '0;
                    else if (age_q[set_i][v] < old) age_d[set_i][v] = age_q[set_i][v] + 1'b1;
                end
            end
            victim_o = '0;
            for (int v = 0; v < WAYS; v++) begin
                if (age_q[set_i][v] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(v);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++)
                    for (int v = 0; v < WAYS; v++)
                        age_q[s][v] <= WAY_W'(v);
            end else begin
                age_q <= age_d;
            end
        end
    end
endmodule

// File: rtl/ctd_dir.sv
module ctd_dir
    import ctd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BLK_BYTES   = 16,
    parameter int CACHE_BYTES = 256,
    parameter int WAYS        = 4,
    parameter int CTX_W       = 4,
    parameter bit USE_PLRU    = 1'b0,
    localparam int OFF_W  = $clog2(BLK_BYTES),
    localparam int SETS   = CACHE_BYTES / WAYS / BLK_BYTES,
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        req_i,
    input  logic [1:0]        perm_i,
    input  logic [CTX_W-1:0]  ctx_i,
    output logic              rsp_valid_o,
    output logic              rsp_flag_o,
    output logic [WAY_W-1:0]  rsp_way_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic [1:0]        rsp_perm_o
);
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        perm_e            perm;
        logic             lk;
        logic [CTX_W-1:0] owner;
    } way_t;

    typedef struct packed {
        way_t [SETS-1:0][WAYS-1:0] tbl;
        logic              rv;
        logic              rf;
        logic [WAY_W-1:0]  rw;
        logic [ADDR_W-1:0] ra;
        perm_e             rp;
    } state_t;

    state_t st_d, st_q;

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    assign set_idx = addr_i[OFF_W +: SET_W];
    assign tag_in  = addr_i[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]            vld_v, gone_v;
    logic [WAYS-1:0][TAG_W-1:0] tag_v;
    logic [WAYS-1:0]            hit_vec, any_vec, free_vec;
    logic [WAY_W-1:0]           hit_idx, any_idx, free_idx, victim;
    logic                       touch;
    logic [WAY_W-1:0]           touch_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            vld_v[w]  = st_q.tbl[set_idx][w].vld;
            gone_v[w] = (st_q.tbl[set_idx][w].perm == PERM_NONE);
            tag_v[w]  = st_q.tbl[set_idx][w].tag;
        end
    end

    ctd_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .vld_i(vld_v), .gone_i(gone_v), .tag_i(tag_v), .tag_q_i(tag_in),
        .hit_vec_o(hit_vec), .any_vec_o(any_vec), .free_vec_o(free_vec),
        .hit_idx_o(hit_idx), .any_idx_o(any_idx), .free_idx_o(free_idx)
    );

    ctd_repl #(.SETS(SETS), .WAYS(WAYS), .USE_PLRU(USE_PLRU)) u_repl (
        .clk(clk), .rst_n(rst_n), .touch_i(touch), .set_i(set_idx),
        .way_i(touch_way), .victim_o(victim)
    );

    logic  hit, anym, room;
    perm_e hit_perm;
    assign hit      = |hit_vec;
    assign anym     = |any_vec;
    assign room     = |free_vec;
    assign hit_perm = st_q.tbl[set_idx][hit_idx].perm;

    always_comb begin
        st_d      = st_q;
        st_d.rv   = (cmd_i != CMD_NOP);
        st_d.rf   = 1'b0;
        st_d.rw   = '0;
        st_d.ra   = '0;
        st_d.rp   = PERM_NONE;
        touch     = 1'b0;
        touch_way = hit_idx;
        case (cmd_e'(cmd_i))
            CMD_ACCESS: if (hit) begin
                touch   = 1'b1;
                st_d.rw = hit_idx;
                st_d.rf = (hit_perm == PERM_RW) ||
                          ((hit_perm == PERM_RO) && (req_i != REQ_STORE));
            end
            CMD_PRESENT: begin
                st_d.rf = hit;
                st_d.rw = hit ? hit_idx : '0;
            end
            CMD_FIND: begin
                st_d.rf = anym;
                st_d.rw = anym ? any_idx : '0;
            end
            CMD_AVAIL: st_d.rf = anym || room;
            CMD_ALLOC: if (!hit && room) begin
                st_d.tbl[set_idx][free_idx].vld   = 1'b1;
                st_d.tbl[set_idx][free_idx].tag   = tag_in;
                st_d.tbl[set_idx][free_idx].perm  = PERM_INV;
                st_d.tbl[set_idx][free_idx].lk    = 1'b0;
                st_d.tbl[set_idx][free_idx].owner = '0;
                touch     = 1'b1;
                touch_way = free_idx;
                st_d.rf   = 1'b1;
                st_d.rw   = free_idx;
            end
            CMD_DEALLOC: if (hit) begin
                st_d.tbl[set_idx][hit_idx].vld = 1'b0;
                st_d.tbl[set_idx][hit_idx].lk  = 1'b0;
                st_d.rf = 1'b1;
                st_d.rw = hit_idx;
            end
            CMD_PROBE: begin
                st_d.rf = !(anym || room);
                st_d.rw = victim;
                st_d.ra = {st_q.tbl[set_idx][victim].tag, set_idx, {OFF_W{1'b0}}};
            end
            CMD_SETPERM: if (hit) begin
                st_d.tbl[set_idx][hit_idx].perm = perm_e'(perm_i);
                if (perm_i != PERM_RW) st_d.tbl[set_idx][hit_idx].lk = 1'b0;
                st_d.rf = 1'b1;
                st_d.rw = hit_idx;
            end
            CMD_GETPERM: if (hit) begin
                st_d.rf = 1'b1;
                st_d.rw = hit_idx;
                st_d.rp = hit_perm;
            end
            CMD_LKSET: if (hit) begin
                st_d.tbl[set_idx][hit_idx].lk    = 1'b1;
                st_d.tbl[set_idx][hit_idx].owner = ctx_i;
                st_d.rf = 1'b1;
                st_d.rw = hit_idx;
            end
            CMD_LKCLR: if (hit) begin
                st_d.tbl[set_idx][hit_idx].lk = 1'b0;
                st_d.rf = 1'b1;
                st_d.rw = hit_idx;
            end
            CMD_LKTEST: if (hit) begin
                st_d.rw = hit_idx;
                st_d.rf = st_q.tbl[set_idx][hit_idx].lk &&
                          (st_q.tbl[set_idx][hit_idx].owner == ctx_i);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rv;
    assign rsp_flag_o  = st_q.rf;
    assign rsp_way_o   = st_q.rw;
    assign rsp_addr_o  = st_q.ra;
    assign rsp_perm_o  = st_q.rp;
endmodule

// File: rtl/ctd_dir_chk.sv
module ctd_dir_chk
    import ctd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd_i,
    input logic              rsp_valid_o,
    input logic              rsp_flag_o,
    input logic [WAY_W-1:0]  rsp_way_o,
    input logic [ADDR_W-1:0] rsp_addr_o,
    input logic [1:0]        rsp_perm_o,
    input logic [WAYS-1:0]   hit_vec,
    input logic [WAYS-1:0]   free_vec
);
    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_NOP) |=> rsp_valid_o);

    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP) |=> !rsp_valid_o);

    a_r14_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> (!rsp_flag_o && rsp_way_o == '0 && rsp_addr_o == '0 && rsp_perm_o == '0));

    a_r9_addr_only_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_PROBE) |=> (rsp_addr_o == '0));

    a_r13_perm_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_GETPERM) |=> (rsp_perm_o == '0));

    a_r4_single_live_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r7_alloc_takes_room: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ALLOC && hit_vec == '0 && free_vec != '0) |=> rsp_flag_o);
endmodule

bind ctd_dir ctd_dir_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i),
    .rsp_valid_o(rsp_valid_o), .rsp_flag_o(rsp_flag_o), .rsp_way_o(rsp_way_o),
    .rsp_addr_o(rsp_addr_o), .rsp_perm_o(rsp_perm_o),
    .hit_vec(hit_vec), .free_vec(free_vec)
);

// File: tb/tb_ctd_dir.sv
module tb_ctd_dir;
    localparam int SETS = 4;
    localparam int WAYS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [3:0]  cmd;
    logic [15:0] addr;
    logic [1:0]  req, perm;
    logic [3:0]  ctx;

    logic        l_v, l_f, p_v, p_f;
    logic [1:0]  l_w, p_w, l_p, p_p;
    logic [15:0] l_a, p_a;

    ctd_dir #(.USE_PLRU(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .req_i(req),
        .perm_i(perm), .ctx_i(ctx), .rsp_valid_o(l_v), .rsp_flag_o(l_f),
        .rsp_way_o(l_w), .rsp_addr_o(l_a), .rsp_perm_o(l_p));

    ctd_dir #(.USE_PLRU(1'b1)) dut_plru (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .req_i(req),
        .perm_i(perm), .ctx_i(ctx), .rsp_valid_o(p_v), .rsp_flag_o(p_f),
        .rsp_way_o(p_w), .rsp_addr_o(p_a), .rsp_perm_o(p_p));

    // Reference model
    int m_vld[SETS][WAYS], m_tag[SETS][WAYS], m_perm[SETS][WAYS], m_lk[SETS][WAYS];
    int rec[SETS][$];            // front = most recent
    int tree[SETS][2*WAYS];

    int e_v, e_f, e_p, e_wl, e_wp, e_al, e_ap;
    string e_tag;
    int checks = 0, fails = 0;
    bit done = 0;

    function automatic logic [15:0] mk(int s, int t);
        return 16'((t << 6) | (s << 4));
    endfunction

    task automatic cmp(string nm, logic v, logic f, logic [1:0] w, logic [15:0] a,
                       logic [1:0] p, int ew, int ea);
        checks++;
        if (v !== e_v[0] || f !== e_f[0] || int'(w) != ew || int'(a) != ea || int'(p) != e_p) begin
            fails++;
            $display("FAIL %s %s: got v=%0d f=%0d w=%0d a=%h p=%0d exp v=%0d f=%0d w=%0d a=%h p=%0d",
                     e_tag, nm, v, f, w, a, p, e_v, e_f, ew, ea, e_p);
        end
    endtask

    task automatic touch(int s, int w);
        int lo, sz, node, half;
        foreach (rec[s][i]) if (rec[s][i] == w) begin rec[s].delete(i); break; end
        rec[s].push_front(w);
        lo = 0; sz = WAYS; node = 1;
        while (sz > 1) begin
            half = sz / 2;
            if (w < lo + half) begin tree[s][node] = 1; node = 2 * node; end
            else begin tree[s][node] = 0; lo += half; node = 2 * node + 1; end
            sz = half;
        end
    endtask

    function automatic int plru_victim(int s);
        int node = 1;
        while (node < WAYS) node = 2 * node + tree[s][node];
        return node - WAYS;
    endfunction

    task automatic model(int c, int a, int r, int pm, int x);
        int s, t, hw, aw, fw, vl, vp;
        s = (a >> 4) % SETS; t = a >> 6;
        hw = -1; aw = -1; fw = -1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_vld[s][w] != 0 && m_tag[s][w] == t) begin
                aw = w;
                if (m_perm[s][w] != 0) hw = w;
            end
            if (m_vld[s][w] == 0 || m_perm[s][w] == 0) fw = w;
        end
        e_v = (c != 0); e_f = 0; e_p = 0; e_wl = 0; e_wp = 0; e_al = 0; e_ap = 0;
        case (c)
            1: begin e_tag = "R3/R5"; if (hw >= 0) begin
                    touch(s, hw); e_wl = hw;
                    e_f = (m_perm[s][hw] == 3) || (m_perm[s][hw] == 2 && r != 2);
               end end
            2: begin e_tag = "R4"; if (hw >= 0) begin e_f = 1; e_wl = hw; end end
            3: begin e_tag = "R4"; if (aw >= 0) begin e_f = 1; e_wl = aw; end end
            4: begin e_tag = "R6"; e_f = (aw >= 0 || fw >= 0); end
            5: begin e_tag = "R7"; if (hw < 0 && fw >= 0) begin
                    m_vld[s][fw] = 1; m_tag[s][fw] = t; m_perm[s][fw] = 1; m_lk[s][fw] = -1;
                    touch(s, fw); e_f = 1; e_wl = fw;
               end end
            6: begin e_tag = "R8"; if (hw >= 0) begin
                    m_vld[s][hw] = 0; m_lk[s][hw] = -1; e_f = 1; e_wl = hw;
               end end
            7: begin e_tag = "R9/R10/R11";
                    e_f = !(aw >= 0 || fw >= 0);
                    vl = rec[s][$]; vp = plru_victim(s);
                    e_wl = vl; e_wp = vp;
                    e_al = (m_tag[s][vl] << 6) | (s << 4);
                    e_ap = (m_tag[s][vp] << 6) | (s << 4);
               end
            8: begin e_tag = "R13"; if (hw >= 0) begin
                    m_perm[s][hw] = pm; if (pm != 3) m_lk[s][hw] = -1;
                    e_f = 1; e_wl = hw;
               end end
            9: begin e_tag = "R13"; if (hw >= 0) begin e_f = 1; e_wl = hw; e_p = m_perm[s][hw]; end end
            10: begin e_tag = "R12"; if (hw >= 0) begin m_lk[s][hw] = x; e_f = 1; e_wl = hw; end end
            11: begin e_tag = "R12"; if (hw >= 0) begin m_lk[s][hw] = -1; e_f = 1; e_wl = hw; end end
            12: begin e_tag = "R12"; if (hw >= 0) begin e_wl = hw; e_f = (m_lk[s][hw] == x); end end
            default: e_tag = "R2";
        endcase
        if (c != 7) begin e_wp = e_wl; e_ap = e_al; end
    endtask

    // Compare the response of the previous command, then issue the next one.
    task automatic step(int c, int a, int r = 0, int pm = 0, int x = 0);
        @(negedge clk);
        cmp("lru", l_v, l_f, l_w, l_a, l_p, e_wl, e_al);
        cmp("plru", p_v, p_f, p_w, p_a, p_p, e_wp, e_ap);
        cmd = 4'(c); addr = 16'(a); req = 2'(r); perm = 2'(pm); ctx = 4'(x);
        model(c, a, r, pm, x);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2: got no end of run, exp end within limit");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c, a;
        rst_n = 1'b0; cmd = '0; addr = '0; req = '0; perm = '0; ctx = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0; m_tag[s][w] = 0; m_perm[s][w] = 0; m_lk[s][w] = -1;
                rec[s].push_back(w);
            end
            for (int n = 0; n < 2 * WAYS; n++) tree[s][n] = 0;
        end
        e_v = 0; e_f = 0; e_p = 0; e_wl = 0; e_wp = 0; e_al = 0; e_ap = 0;
        e_tag = "R14";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R14 reset state is checked by the first step; R1 set/tag split below.
        step(0, 0);
        step(1, mk(1, 1));                   // R3 miss on empty directory
        step(4, mk(1, 1));                   // R6 room
        step(5, mk(1, 1) | 4'hA);            // R7 alloc, R1 offset ignored
        step(2, mk(1, 1));                   // R4 present
        step(2, mk(2, 1));                   // R1 same tag, other set: absent
        step(1, mk(1, 1), 0);                // R3 invalid line misses, R5 touches
        step(9, mk(1, 1));                   // R13 reads back 1
        step(8, mk(1, 1), 0, 2);             // read-only
        step(1, mk(1, 1), 0);                // R3 load hits
        step(1, mk(1, 1), 1);                // R3 fetch hits
        step(1, mk(1, 1), 2);                // R3 store misses
        step(8, mk(1, 1), 0, 3);             // read-write
        step(1, mk(1, 1), 2);                // R3 store hits
        step(10, mk(1, 1), 0, 0, 5);         // R12 lock by 5
        step(12, mk(1, 1), 0, 0, 5);         // R12 true
        step(12, mk(1, 1), 0, 0, 6);         // R12 false
        step(8, mk(1, 1), 0, 3);             // R13 keeps lock
        step(12, mk(1, 1), 0, 0, 5);
        step(8, mk(1, 1), 0, 2);             // R13 clears lock
        step(12, mk(1, 1), 0, 0, 5);
        for (int t = 2; t <= 4; t++) step(5, mk(1, t));
        step(4, mk(1, 9));                   // R6 full set
        step(7, mk(1, 9));                   // R9 R10 R11 victim
        step(5, mk(1, 9));                   // R7 refused
        step(1, mk(1, 2)); step(1, mk(1, 4));
        step(7, mk(1, 9));
        step(8, mk(1, 3), 0, 0);             // to not present
        step(2, mk(1, 3)); step(3, mk(1, 3)); // R4
        step(4, mk(1, 9)); step(7, mk(1, 9));
        step(5, mk(1, 9));                   // R7 reuses permission-0 way
        step(6, mk(1, 2)); step(2, mk(1, 2)); // R8
        step(5, mk(1, 1));                   // R7 refused: present
        step(11, mk(1, 1)); step(12, mk(1, 1), 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            c = int'($urandom_range(0, 15));
            if (c > 12) c = 5;
            a = int'(mk(int'($urandom_range(0, 1)), int'($urandom_range(0, 5)))) | int'($urandom_range(0, 15));
            step(c, a, int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
        end
        step(0, 0);
        step(0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule